// File: doc/BRIEF.md
# Flash/RAM Bank-Switching Glue Controller

This block is the glue logic between the external bus of an 8-bit microcontroller that keeps code and data in separate address spaces and two external memories: a reprogrammable flash that holds application code, and a data RAM. A one-bit mode register, written by software through a port-write strobe, selects one of two memory maps. In Normal Mode the flash answers only code fetches and the RAM answers all data reads and writes across the full 64 KB data space. In Programming Mode the RAM output driver is switched off and the data read and write strobes are steered to the flash instead. The processor, running from its internal ROM, can then erase and program its own code store with ordinary data-space accesses.

The block also models the internal ROM boundary, which is a parameter of 8 KB or 16 KB. Code fetches below the boundary are served by the internal ROM and raise no external strobe. Fetches at or above it drive the external program-store strobe. Code must never be fetched from outside the ROM while Programming Mode is active. Any such fetch sets a sticky violation flag, which only reset clears. All memory strobes are active low. They are formed combinationally from the mode register and the bus strobes, so they add no clock latency.

Top module: `bank_switch_glue`

## Requirements
- R1: While reset is asserted and directly after it, the mode output `mode_n` is 1 (Normal Mode), `illegal_fetch` is 0 and `ram_oe_n` is 0.
- R2: The mode register takes `mode_wdata` at a rising clock edge where `mode_wr_n` is 0. At edges where `mode_wr_n` is 1 it keeps its value. A stored 1 means Normal Mode and a stored 0 means Programming Mode.
- R3: `ext_code_n` is 0 exactly when `fetch_req` is 1 and `fetch_addr` is greater than or equal to the ROM size (ROM_KB*1024, which is 0x4000 by default or 0x2000 for ROM_KB=8). Otherwise it is 1.
- R4: `flash_rd_n` is 0 when `ext_code_n` is 0, or when `mode_n` is 0 and `data_rd_n` is 0. Otherwise it is 1.
- R5: `flash_wr_n` is 0 only when `mode_n` is 0 and `data_wr_n` is 0, so flash writes are blocked in Normal Mode.
- R6: `ram_oe_n` equals the inverse of `mode_n`, so the RAM is disabled throughout Programming Mode.
- R7: `ram_rd_n` and `ram_wr_n` copy `data_rd_n` and `data_wr_n` unchanged in both modes.
- R8: `illegal_fetch` becomes 1 after a rising edge at which `ext_code_n` and `mode_n` are both 0. It stays 1 until reset and never becomes 1 without that cause.
- R9: The strobe outputs in R3 to R7 respond to input and mode changes in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_wr_n | input | 1 | Port-write strobe for the mode register, active low |
| mode_wdata | input | 1 | Mode value to load (1 = Normal, 0 = Programming) |
| fetch_req | input | 1 | Code fetch in progress |
| fetch_addr | input | ADDR_W | Code fetch address |
| data_rd_n | input | 1 | Data-space read strobe, active low |
| data_wr_n | input | 1 | Data-space write strobe, active low |
| ext_code_n | output | 1 | External program-store strobe, active low |
| mode_n | output | 1 | Current mode, 0 = Programming Mode |
| flash_rd_n | output | 1 | Flash read strobe, active low |
| flash_wr_n | output | 1 | Flash write strobe, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_rd_n | output | 1 | RAM read strobe, active low |
| ram_wr_n | output | 1 | RAM write strobe, active low |
| illegal_fetch | output | 1 | Sticky illegal-fetch flag |

## Verification
The strobe outputs are due in the same cycle as their inputs. The bench therefore drives each input pattern on a falling clock edge and samples one time unit later, before any rising edge, and compares against the equations recomputed from the truth tables. A mode write is due one rising edge after the strobe, so the bench checks the new mode at the following falling edge. The violation flag is due one rising edge after an illegal fetch. It is checked at the next falling edge, and it is checked again several cycles later to confirm that it holds. All 16 combinations of program-store strobe, mode, read and write are swept, and the ROM boundary is probed one byte below and at the limit for both ROM sizes.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

  // Byte size of the internal ROM for a size given in KB.
  function automatic int unsigned rom_bytes(input int unsigned kb);
    return kb * 1024;
  endfunction

  // Flash read: code strobe, or a data read while in Programming Mode.
  function automatic logic flash_rd_n(input logic code_n, input logic pm_n,
                                      input logic rd_n);
    return code_n & (pm_n | rd_n);
  endfunction

  // Flash write: only a data write while in Programming Mode.
  function automatic logic flash_wr_n(input logic pm_n, input logic wr_n);
    return pm_n | wr_n;
  endfunction

  // RAM output enable: the RAM is driven only in Normal Mode.
  function automatic logic ram_oe_n(input logic pm_n);
    return ~pm_n;
  endfunction

endpackage

// File: rtl/bsg_mode_reg.sv
module bsg_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_n,
  input  logic wdata,
  output logic pm_n
);
  logic load_evt;
  assign load_evt = ~wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pm_n <= 1'b1;
    else if (load_evt) pm_n <= wdata;
  end

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> (pm_n == $past(wdata))); // R2
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |=> $stable(pm_n)); // R2
endmodule

// File: rtl/bsg_code_decode.sv
module bsg_code_decode #(
  parameter int unsigned ROM_KB = 16,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              code_n
);
  import bsg_pkg::*;
  localparam int unsigned ROM_BYTES = rom_bytes(ROM_KB);
  localparam logic [ADDR_W-1:0] ROM_LIMIT = ADDR_W'(ROM_BYTES);

  logic above_rom;
  assign above_rom = (fetch_addr >= ROM_LIMIT);
  assign code_n    = ~(fetch_req & above_rom);

  AST_ROM_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_addr < ROM_LIMIT) |-> code_n); // R3
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_req |-> code_n); // R3
endmodule

// File: rtl/bsg_strobe_route.sv
module bsg_strobe_route (
  input  logic clk,
  input  logic rst_n,
  input  logic pm_n,
  input  logic code_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic flash_rd_n,
  output logic flash_wr_n,
  output logic ram_oe_n,
  output logic ram_rd_n,
  output logic ram_wr_n
);
  import bsg_pkg::*;

  assign flash_rd_n = bsg_pkg::flash_rd_n(code_n, pm_n, rd_n);
  assign flash_wr_n = bsg_pkg::flash_wr_n(pm_n, wr_n);
  assign ram_oe_n   = bsg_pkg::ram_oe_n(pm_n);
  assign ram_rd_n   = rd_n;
  assign ram_wr_n   = wr_n;

  AST_NO_FLASH_WR_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    pm_n |-> flash_wr_n); // R5
  AST_NORMAL_RD_IS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    pm_n |-> (flash_rd_n == code_n)); // R4
  AST_RAM_OFF_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    !pm_n |-> ram_oe_n); // R6
  AST_RAM_ON_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    pm_n |-> !ram_oe_n); // R6
endmodule

// File: rtl/bsg_viol_mon.sv
module bsg_viol_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic pm_n,
  input  logic code_n,
  output logic viol
);
  logic bad_fetch;
  assign bad_fetch = ~pm_n & ~code_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         viol <= 1'b0;
    else if (bad_fetch) viol <= 1'b1;
  end

  AST_VIOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    bad_fetch |=> viol); // R8
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> viol); // R8
  AST_VIOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!viol && !bad_fetch) |=> !viol); // R8
endmodule

// File: rtl/bank_switch_glue.sv
module bank_switch_glue #(
  parameter int unsigned ROM_KB = 16,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr_n,
  input  logic              mode_wdata,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              data_rd_n,
  input  logic              data_wr_n,
  output logic              ext_code_n,
  output logic              mode_n,
  output logic              flash_rd_n,
  output logic              flash_wr_n,
  output logic              ram_oe_n,
  output logic              ram_rd_n,
  output logic              ram_wr_n,
  output logic              illegal_fetch
);
  logic pm_n_w;
  logic code_n_w;

  bsg_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .wr_n(mode_wr_n), .wdata(mode_wdata),
    .pm_n(pm_n_w)
  );

  bsg_code_decode #(.ROM_KB(ROM_KB), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .code_n(code_n_w)
  );

  bsg_strobe_route u_route (
    .clk(clk), .rst_n(rst_n), .pm_n(pm_n_w), .code_n(code_n_w),
    .rd_n(data_rd_n), .wr_n(data_wr_n),
    .flash_rd_n(flash_rd_n), .flash_wr_n(flash_wr_n),
    .ram_oe_n(ram_oe_n), .ram_rd_n(ram_rd_n), .ram_wr_n(ram_wr_n)
  );

  bsg_viol_mon u_viol (
    .clk(clk), .rst_n(rst_n), .pm_n(pm_n_w), .code_n(code_n_w),
    .viol(illegal_fetch)
  );

  assign ext_code_n = code_n_w;
  assign mode_n     = pm_n_w;

  always_comb begin
    if (rst_n) begin
      AST_RAM_STROBE_PASS: assert (ram_rd_n == data_rd_n && ram_wr_n == data_wr_n); // R7
    end
  end
endmodule

// File: tb/sim_bank_switch_glue.sv
module sim_bank_switch_glue;
  localparam int CLK_P = 10;
  localparam int ROM_A = 16 * 1024;
  localparam int ROM_B = 8 * 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr_n = 1'b1, mode_wdata = 1'b1;
  logic fetch_req = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic data_rd_n = 1'b1, data_wr_n = 1'b1;
  logic ext_code_n, mode_n, flash_rd_n, flash_wr_n, ram_oe_n, ram_rd_n, ram_wr_n, illegal_fetch;
  logic b_code_n, b_mode_n, b_frd, b_fwr, b_oe, b_rrd, b_rwr, b_viol;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  bank_switch_glue u0 (
    .clk(clk), .rst_n(rst_n), .mode_wr_n(mode_wr_n), .mode_wdata(mode_wdata),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .data_rd_n(data_rd_n), .data_wr_n(data_wr_n),
    .ext_code_n(ext_code_n), .mode_n(mode_n), .flash_rd_n(flash_rd_n),
    .flash_wr_n(flash_wr_n), .ram_oe_n(ram_oe_n), .ram_rd_n(ram_rd_n),
    .ram_wr_n(ram_wr_n), .illegal_fetch(illegal_fetch)
  );

  bank_switch_glue #(.ROM_KB(8)) u1 (
    .clk(clk), .rst_n(rst_n), .mode_wr_n(mode_wr_n), .mode_wdata(mode_wdata),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .data_rd_n(data_rd_n), .data_wr_n(data_wr_n),
    .ext_code_n(b_code_n), .mode_n(b_mode_n), .flash_rd_n(b_frd),
    .flash_wr_n(b_fwr), .ram_oe_n(b_oe), .ram_rd_n(b_rrd),
    .ram_wr_n(b_rwr), .illegal_fetch(b_viol)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic v);
    @(negedge clk);
    mode_wr_n = 1'b0; mode_wdata = v;
    @(negedge clk);
    mode_wr_n = 1'b1; mode_wdata = ~v;
    chk("R2 mode load", int'(mode_n), int'(v));
  endtask

  // Sweep psen/rd/wr for the current mode; expected values from truth tables.
  task automatic sweep(input logic pm);
    for (int i = 7; i >= 0; i--) begin
      logic ps, rd, wr, e_frd, e_fwr;
      ps = i[2]; rd = i[1]; wr = i[0];
      @(negedge clk);
      fetch_req  = ~ps;
      fetch_addr = 16'(ROM_A + i * 37);
      data_rd_n  = rd; data_wr_n = wr;
      #1;
      e_frd = (ps == 1'b0) ? 1'b0 : ((pm == 1'b0 && rd == 1'b0) ? 1'b0 : 1'b1);
      e_fwr = (pm == 1'b0 && wr == 1'b0) ? 1'b0 : 1'b1;
      chk("R3 ext code strobe", int'(ext_code_n), int'(ps));
      chk("R4 flash read", int'(flash_rd_n), int'(e_frd));
      chk("R5 flash write", int'(flash_wr_n), int'(e_fwr));
      chk("R6 ram oe", int'(ram_oe_n), (pm == 1'b1) ? 0 : 1);
      chk("R7 ram rd", int'(ram_rd_n), int'(rd));
      chk("R7 ram wr", int'(ram_wr_n), int'(wr));
      if (i == 4) chk("R8 no flag without illegal fetch", int'(illegal_fetch), 0);
    end
    @(negedge clk);
    fetch_req = 1'b0; data_rd_n = 1'b1; data_wr_n = 1'b1;
  endtask

  task automatic probe(input logic req, input int addr);
    @(negedge clk);
    fetch_req = req; fetch_addr = 16'(addr);
    #1;
    chk("R3 boundary 16K", int'(ext_code_n), (req && addr >= ROM_A) ? 0 : 1);
    chk("R3 boundary 8K", int'(b_code_n), (req && addr >= ROM_B) ? 0 : 1);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 reset mode", int'(mode_n), 1);
    chk("R1 reset flag", int'(illegal_fetch), 0);
    chk("R1 reset ram oe", int'(ram_oe_n), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    do_reset();
    @(negedge clk);
    chk("R1 after reset mode", int'(mode_n), 1);

    // R2 hold: write strobe idle, data opposite.
    @(negedge clk);
    mode_wdata = 1'b0;
    @(negedge clk);
    chk("R2 mode hold", int'(mode_n), 1);

    // Normal Mode sweep: flag must stay clear.
    sweep(1'b1);
    chk("R8 no flag in Normal Mode", int'(illegal_fetch), 0);

    // R9: mode change reaches strobes at once with data strobes held low.
    @(negedge clk);
    data_rd_n = 1'b0; data_wr_n = 1'b0;
    #1;
    chk("R9 normal flash wr blocked", int'(flash_wr_n), 1);
    mode_wr_n = 1'b0; mode_wdata = 1'b0;
    @(posedge clk);
    #1;
    chk("R9 prog flash wr same cycle", int'(flash_wr_n), 0);
    chk("R9 prog flash rd same cycle", int'(flash_rd_n), 0);
    @(negedge clk);
    mode_wr_n = 1'b1; data_rd_n = 1'b1; data_wr_n = 1'b1;

    // Programming Mode sweep: illegal fetches at the end.
    sweep(1'b0);
    chk("R8 flag set", int'(illegal_fetch), 1);
    set_mode(1'b1);
    repeat (4) @(negedge clk);
    chk("R8 flag sticky", int'(illegal_fetch), 1);

    do_reset();
    @(negedge clk);
    chk("R8 flag cleared by reset", int'(illegal_fetch), 0);

    // ROM boundary for both sizes, Normal Mode.
    probe(1'b1, ROM_B - 1);
    probe(1'b1, ROM_B);
    probe(1'b1, ROM_A - 1);
    probe(1'b1, ROM_A);
    probe(1'b1, 16'hFFFF);
    probe(1'b0, 16'hFFFF);
    probe(1'b1, 0);

    // 8K variant: fetch just above its boundary in Programming Mode flags it.
    set_mode(1'b0);
    probe(1'b1, ROM_B);
    @(negedge clk);
    fetch_req = 1'b0;
    chk("R8 8K flag set", int'(b_viol), 1);
    chk("R8 16K no flag below its boundary", int'(illegal_fetch), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule